// File: doc/BRIEF.md
# Gated Time Pulse Accumulator

This block measures how long an external gate signal stays at its active level. While the gate is active, the block divides the system clock by 64 and adds one to a 16-bit count register on every 64th active cycle. When the gate leaves its active level, the block sets an edge flag. A polarity bit selects which level is active, so a high pulse or a low pulse can be timed.

Software can read and write the count, so it can preload a start value. When the count rolls over from 0xFFFF to 0x0000, the block sets an overflow flag. Each flag has its own interrupt enable, and the two enabled flags are ORed into one interrupt request line. Software clears a flag by writing a one to its bit.

The gate input is asynchronous. It passes through a two-stage synchronizer before it is used for gating or edge detection.

Top module: `gated_pulse_acc`

## Requirements
- R1: After a synchronous reset, the control register, the flag register and the count all read 0, and `irq` is low.
- R2: The registers are selected by `reg_addr`. Address 0 is control, with enable at bit 6, gated-time mode at bit 5, polarity at bit 4, overflow interrupt enable at bit 1 and edge interrupt enable at bit 0. Address 1 is flags, with overflow at bit 1 and edge at bit 0. Address 2 is the 16-bit count, which can be read and written. Undefined bits and address 3 read as 0.
- R3: While enabled, in gated mode, with the gate active, the count rises by exactly one per 64 active clock cycles. The prescaler keeps its partial progress while the gate is inactive.
- R4: With polarity 0, the gate is active while high, and a falling edge on the gate sets the edge flag.
- R5: With polarity 1, the gate is active while low, and a rising edge on the gate sets the edge flag.
- R6: While enable is 0, or while gated mode is 0, the count does not change and the edge flag is not set. Clearing enable also clears the prescaler's partial progress.
- R7: A count step from 0xFFFF to 0x0000 sets the overflow flag.
- R8: Writing 1 to a flag bit at address 1 clears that flag. Writing 0 leaves the flag unchanged.
- R9: `irq` is high exactly when (the overflow flag and the overflow enable are both set) or (the edge flag and the edge enable are both set).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| gate_in | input | 1 | Asynchronous gate input |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that:
- the count only ever moves by one step when it is not written;
- the count stays still while the block is disabled;
- a disable clears the prescaler;
- a rollover raises the overflow flag;
- writing a zero never clears a flag;
- `irq` stays low with both enables off.

Only the bench scenarios can show the 64-cycle ratio and the prescaler residue that carries across gate pulses, the edge sense chosen by each polarity, and the clearing of flags at the register interface.

// File: rtl/gta_pkg.sv
`timescale 1ns/1ps
package gta_pkg;
    localparam int CNT_W = 16;
    localparam int DIV   = 64;

    // Control bit positions
    localparam int CB_EN    = 6;
    localparam int CB_GATED = 5;
    localparam int CB_POL   = 4;
    localparam int CB_OVIE  = 1;
    localparam int CB_EIE   = 0;

    // Flag bit positions
    localparam int FB_OVF = 1;
    localparam int FB_EDG = 0;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_FLAG  = 2'd1,
        SEL_COUNT = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic en;
        logic gated;
        logic pol;
        logic ovie;
        logic eie;
    } ctrl_t;

    typedef struct packed {
        logic ovf;
        logic edg;
    } flag_t;

    function automatic ctrl_t ctrl_from_byte(input logic [7:0] b);
        ctrl_t c;
        c.en    = b[CB_EN];
        c.gated = b[CB_GATED];
        c.pol   = b[CB_POL];
        c.ovie  = b[CB_OVIE];
        c.eie   = b[CB_EIE];
        return c;
    endfunction

    function automatic logic [7:0] ctrl_to_byte(input ctrl_t c);
        logic [7:0] b;
        b           = '0;
        b[CB_EN]    = c.en;
        b[CB_GATED] = c.gated;
        b[CB_POL]   = c.pol;
        b[CB_OVIE]  = c.ovie;
        b[CB_EIE]   = c.eie;
        return b;
    endfunction

    function automatic logic [7:0] flag_to_byte(input flag_t f);
        logic [7:0] b;
        b         = '0;
        b[FB_OVF] = f.ovf;
        b[FB_EDG] = f.edg;
        return b;
    endfunction
endpackage

// File: rtl/gta_gate_sync.sv
`timescale 1ns/1ps
module gta_gate_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic gate_in,
    input  logic pol,
    output logic gate_act,
    output logic trail_edge
);
    logic [STAGES-1:0] sync_q;
    logic              act_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= gate_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[STAGES-2:0], gate_in};
            end
        end
    endgenerate

    // Polarity 0: high is active. Polarity 1: low is active.
    assign gate_act = sync_q[STAGES-1] ^ pol;

    always_ff @(posedge clk) begin
        if (rst) act_q <= 1'b0;
        else     act_q <= gate_act;
    end

    assign trail_edge = act_q & ~gate_act;
endmodule

// File: rtl/gta_prescaler.sv
`timescale 1ns/1ps
module gta_prescaler #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] cnt_q;
    logic [PW-1:0] cnt_nx;

    assign tick = run && (cnt_q == LAST);

    generate
        if ((DIV & (DIV - 1)) == 0) begin : g_pow2
            assign cnt_nx = cnt_q + 1'b1;
        end else begin : g_any
            assign cnt_nx = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clr) cnt_q <= '0;
        else if (run)   cnt_q <= cnt_nx;
    end

    // R6
    prescaler_clr_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0));
endmodule

// File: rtl/gated_pulse_acc.sv
`timescale 1ns/1ps
module gated_pulse_acc #(
    parameter int CNT_W = gta_pkg::CNT_W,
    parameter int DIV   = gta_pkg::DIV
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gate_in,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    output logic             irq
);
    import gta_pkg::*;

    localparam int PAD = CNT_W - 8;

    ctrl_t            ctrl_q;
    flag_t            flag_q;
    logic [CNT_W-1:0] count_q;
    reg_sel_e         sel;
    logic             ctrl_wr, flag_wr, count_wr;
    logic             gate_act, trail_edge, run, tick;
    logic             edge_hit, ovf_hit;

    assign sel      = reg_sel_e'(reg_addr);
    assign ctrl_wr  = reg_wr && (sel == SEL_CTRL);
    assign flag_wr  = reg_wr && (sel == SEL_FLAG);
    assign count_wr = reg_wr && (sel == SEL_COUNT);

    gta_gate_sync #(.STAGES(2)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .gate_in    (gate_in),
        .pol        (ctrl_q.pol),
        .gate_act   (gate_act),
        .trail_edge (trail_edge)
    );

    assign run = ctrl_q.en && ctrl_q.gated && gate_act;

    gta_prescaler #(.DIV(DIV)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .clr  (~ctrl_q.en),
        .run  (run),
        .tick (tick)
    );

    assign edge_hit = ctrl_q.en && ctrl_q.gated && trail_edge;
    assign ovf_hit  = tick && (count_q == '1) && !count_wr;

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= ctrl_from_byte(reg_wdata[7:0]);
    end

    always_ff @(posedge clk) begin
        if (rst)           count_q <= '0;
        else if (count_wr) count_q <= reg_wdata;
        else if (tick)     count_q <= count_q + 1'b1;
    end

    // A new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
        end else begin
            flag_q.ovf <= ovf_hit  | (flag_q.ovf & ~(flag_wr & reg_wdata[FB_OVF]));
            flag_q.edg <= edge_hit | (flag_q.edg & ~(flag_wr & reg_wdata[FB_EDG]));
        end
    end

    always_comb begin
        unique case (sel)
            SEL_CTRL:  reg_rdata = {{PAD{1'b0}}, ctrl_to_byte(ctrl_q)};
            SEL_FLAG:  reg_rdata = {{PAD{1'b0}}, flag_to_byte(flag_q)};
            SEL_COUNT: reg_rdata = count_q;
            default:   reg_rdata = '0;
        endcase
    end

    assign irq = (flag_q.ovf & ctrl_q.ovie) | (flag_q.edg & ctrl_q.eie);

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(count_wr) && (count_q != $past(count_q)))
            |-> (count_q == $past(count_q) + 1'b1));

    // R6
    disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.en && !count_wr) |=> $stable(count_q));

    // R7
    ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && (count_q == '1) && !count_wr) |=> flag_q.ovf);

    // R8
    flag_w0_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_wr && !reg_wdata[FB_EDG] && flag_q.edg) |=> flag_q.edg);

    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.ovie && !ctrl_q.eie) |-> !irq);
endmodule

// File: tb/gated_pulse_acc_tb.sv
`timescale 1ns/1ps
module gated_pulse_acc_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        gate_in = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [1:0]  a;
        logic [15:0] v;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    always #10 clk = ~clk;

    gated_pulse_acc u_dut (
        .clk       (clk),
        .rst       (rst),
        .gate_in   (gate_in),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    // Monitor: pops expected items and compares them with the read data.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t it;
                it = sb_q.pop_front();
                checks++;
                if (reg_rdata !== it.v) begin
                    errors++;
                    $display("FAIL %s addr=%0d actual=%h expected=%h",
                             it.tag, it.a, reg_rdata, it.v);
                end
            end
        end
    end

    task automatic expect_reg(input logic [1:0] a, input logic [15:0] v, input string tag);
        exp_t it;
        @(negedge clk);
        reg_addr = a;
        it.a = a;
        it.v = v;
        it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk);
        #2;
    endtask

    task automatic check_irq(input logic v, input string tag);
        @(negedge clk);
        checks++;
        if (irq !== v) begin
            errors++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, v);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        reg_wdata = d;
        reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Holds the gate at the active level for n cycles, then returns it to idle.
    task automatic pulse(input logic act_lvl, input int n);
        @(negedge clk);
        gate_in = act_lvl;
        repeat (n) @(negedge clk);
        gate_in = ~act_lvl;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        expect_reg(2'd0, 16'h0000, "R1 ctrl after reset");
        expect_reg(2'd1, 16'h0000, "R1 flags after reset");
        expect_reg(2'd2, 16'h0000, "R1 count after reset");
        check_irq(1'b0, "R1 irq after reset");

        // R2: control field positions, undefined bits read 0
        wr(2'd0, 16'h00FF);
        expect_reg(2'd0, 16'h0073, "R2 ctrl defined bits only");
        wr(2'd0, 16'h0060);
        expect_reg(2'd0, 16'h0060, "R2 ctrl enable+gated");
        expect_reg(2'd3, 16'h0000, "R2 unused address");

        // R3 / R4: 192 active-high cycles give 3 counts; the falling edge sets the edge flag
        pulse(1'b1, 192);
        expect_reg(2'd2, 16'd3, "R3 three counts");
        expect_reg(2'd1, 16'h0001, "R4 falling edge flag");
        check_irq(1'b0, "R9 edge without enable");

        // R8: writing 0 keeps the flag, writing 1 clears it
        wr(2'd1, 16'h0000);
        expect_reg(2'd1, 16'h0001, "R8 write zero no effect");
        wr(2'd1, 16'h0001);
        expect_reg(2'd1, 16'h0000, "R8 write one clears");

        // R3: residue kept across inactive gate
        pulse(1'b1, 32);
        expect_reg(2'd2, 16'd3, "R3 half period no count");
        pulse(1'b1, 32);
        expect_reg(2'd2, 16'd4, "R3 residue completes count");

        // R6: disabling clears the residue
        pulse(1'b1, 32);
        wr(2'd0, 16'h0000);
        wr(2'd0, 16'h0060);
        pulse(1'b1, 32);
        expect_reg(2'd2, 16'd4, "R6 residue cleared by disable");
        pulse(1'b1, 32);
        expect_reg(2'd2, 16'd5, "R6 count resumes");
        wr(2'd1, 16'h0003);

        // R6: disabled, and enabled without gated mode
        wr(2'd0, 16'h0000);
        pulse(1'b1, 128);
        expect_reg(2'd2, 16'd5, "R6 disabled no count");
        expect_reg(2'd1, 16'h0000, "R6 disabled no edge flag");
        wr(2'd0, 16'h0040);
        pulse(1'b1, 128);
        expect_reg(2'd2, 16'd5, "R6 non-gated mode no count");
        expect_reg(2'd1, 16'h0000, "R6 non-gated mode no flag");

        // R2 / R7 / R9: preload, rollover, interrupt
        wr(2'd0, 16'h0062);
        wr(2'd2, 16'hFFFF);
        expect_reg(2'd2, 16'hFFFF, "R2 preload readback");
        pulse(1'b1, 64);
        expect_reg(2'd2, 16'h0000, "R7 rollover to zero");
        expect_reg(2'd1, 16'h0003, "R7 overflow and edge flags");
        check_irq(1'b1, "R9 overflow irq");
        wr(2'd1, 16'h0002);
        expect_reg(2'd1, 16'h0001, "R8 clear overflow only");
        check_irq(1'b0, "R9 edge flag masked");
        wr(2'd0, 16'h0063);
        check_irq(1'b1, "R9 edge irq enabled");
        wr(2'd1, 16'h0003);
        check_irq(1'b0, "R9 irq drops after clear");

        // R5: low-active gate, rising edge sets the flag
        wr(2'd0, 16'h0000);
        @(negedge clk);
        gate_in = 1'b1;
        repeat (4) @(negedge clk);
        wr(2'd0, 16'h0070);
        wr(2'd1, 16'h0003);
        wr(2'd2, 16'h1234);
        expect_reg(2'd1, 16'h0000, "R5 flags clear before pulse");
        pulse(1'b0, 128);
        expect_reg(2'd2, 16'h1236, "R5 low-active counting");
        expect_reg(2'd1, 16'h0001, "R5 rising edge flag");

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule